// File: doc/BRIEF.md
# Calendar Real-Time Clock with Register Bus

This block keeps calendar time as binary fields: second, minute, hour, day of month, month, year within the century and century. Software reaches it through a plain 32-bit register bus with word addresses. One word packs the time of day, another the date. A control word carries a run enable and a write unlock. While the clock runs, a one-cycle `sec_tick` pulse from the surrounding chip advances the count by one second. The carry ripples through the fields with month lengths and the leap-year rule applied.

Software sets the time in three steps. It sets the unlock bit, writes the two counter words, then sets the run bit. Two further addresses are decoded but do nothing: they read zero and discard writes. The bus has no back-pressure. A write is taken on the rising edge of the cycle in which `bus_sel` and `bus_wr` are high. Read data is a combinational function of the address in the same cycle, and is zero when no read is presented.

Top module: `cal_rtc`

## Requirements
- R1: Reset clears the control, time and date words, so the clock starts stopped and locked and every address reads zero.
- R2: Word address 0 is the time word, 1 the date word, 2 an alarm word, 4 control and 5 an alarm status word. The alarm word, the alarm status word and the unmapped addresses 3, 6 and 7 read zero, and writes to them change no other register.
- R3: Control bit 0 is run and bit 1 is unlock. A control write is always accepted, and the other control bits read zero.
- R4: The time word holds the second in bits [5:0], the minute in [13:8], the hour in [20:16] and the day of month in [28:24]. All other bits read zero.
- R5: The date word holds the month (1 = January) in bits [3:0], the year within the century in [14:8] and the century in [20:16]. All other bits read zero.
- R6: A write to the time or date word is discarded unless unlock is 1.
- R7: While run is 1, each `sec_tick` pulse advances the time by one second. While run is 0, ticks are ignored and the stored value holds. A read always returns the current count.
- R8: The second wraps 59 to 0 and carries into the minute. The minute wraps 59 to 0 and carries into the hour. The hour wraps 23 to 0 and carries into the day.
- R9: After the last day of the month, the day becomes 1 and the month advances. April, June, September and November have 30 days, February has 28 or 29, and the rest have 31. December wraps to January and carries into the year.
- R10: The year field wraps 99 to 0 and increments the century.
- R11: February has 29 days when the full year (century × 100 + year) is divisible by 4, except century years not divisible by 400.
- R12: An accepted counter write in the same cycle as an effective tick wins. Neither word advances in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| bus_sel | input | 1 | Bus access present this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_waddr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |

## Verification
A wrong carry or a wrong month-length decision shows up in the very next read of the time or date word after the tick that crosses the boundary. The bench therefore loads a value just before each boundary, issues one tick and reads both words back. A lock or priority fault shows as a counter word that differs from the value last written, or from the value before the write, on the read that follows the offending access. A faulty field mask or decode shows up at once on a read of an all-ones pattern or of an unused address.

// File: rtl/cal_rtc_pkg.sv
package cal_rtc_pkg;
  localparam int BUS_W   = 32;
  localparam int SEC_W   = 6;
  localparam int MIN_W   = 6;
  localparam int HOUR_W  = 5;
  localparam int DAY_W   = 5;
  localparam int MON_W   = 4;
  localparam int YEAR_W  = 7;
  localparam int CENT_W  = 5;

  localparam int SEC_POS  = 0;
  localparam int MIN_POS  = 8;
  localparam int HOUR_POS = 16;
  localparam int DAY_POS  = 24;
  localparam int MON_POS  = 0;
  localparam int YEAR_POS = 8;
  localparam int CENT_POS = 16;

  localparam int LANES  = 7;
  localparam int LANE_W = 7;
  localparam int SEL_W  = 3;

  localparam int RUN_BIT    = 0;
  localparam int UNLOCK_BIT = 1;

  typedef enum logic [SEL_W-1:0] {
    SEL_TOD    = 3'd0,
    SEL_CAL    = 3'd1,
    SEL_ALARM  = 3'd2,
    SEL_GAP    = 3'd3,
    SEL_CTRL   = 3'd4,
    SEL_ALSTAT = 3'd5,
    SEL_HI6    = 3'd6,
    SEL_HI7    = 3'd7
  } reg_sel_e;

  typedef struct packed {
    logic [DAY_W-1:0]  day;
    logic [HOUR_W-1:0] hour;
    logic [MIN_W-1:0]  minute;
    logic [SEC_W-1:0]  sec;
  } tod_t;

  typedef struct packed {
    logic [CENT_W-1:0] cent;
    logic [YEAR_W-1:0] year;
    logic [MON_W-1:0]  mon;
  } cal_t;

  function automatic logic [BUS_W-1:0] pack_tod(input tod_t t);
    logic [BUS_W-1:0] w;
    w = '0;
    w[DAY_POS  +: DAY_W]  = t.day;
    w[HOUR_POS +: HOUR_W] = t.hour;
    w[MIN_POS  +: MIN_W]  = t.minute;
    w[SEC_POS  +: SEC_W]  = t.sec;
    return w;
  endfunction

  function automatic logic [BUS_W-1:0] pack_cal(input cal_t c);
    logic [BUS_W-1:0] w;
    w = '0;
    w[CENT_POS +: CENT_W] = c.cent;
    w[YEAR_POS +: YEAR_W] = c.year;
    w[MON_POS  +: MON_W]  = c.mon;
    return w;
  endfunction

  function automatic tod_t unpack_tod(input logic [BUS_W-1:0] w);
    tod_t t;
    t.day    = w[DAY_POS  +: DAY_W];
    t.hour   = w[HOUR_POS +: HOUR_W];
    t.minute = w[MIN_POS  +: MIN_W];
    t.sec    = w[SEC_POS  +: SEC_W];
    return t;
  endfunction

  function automatic cal_t unpack_cal(input logic [BUS_W-1:0] w);
    cal_t c;
    c.cent = w[CENT_POS +: CENT_W];
    c.year = w[YEAR_POS +: YEAR_W];
    c.mon  = w[MON_POS  +: MON_W];
    return c;
  endfunction
endpackage

// File: rtl/cal_wrap_stage.sv
module cal_wrap_stage #(
  parameter int W = 7
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  input  logic         carry_in,
  output logic [W-1:0] nxt,
  output logic         carry_out
);
  logic at_top;
  assign at_top    = (cur >= hi);
  assign carry_out = carry_in & at_top;

  always_comb begin
    if (!carry_in)   nxt = cur;
    else if (at_top) nxt = lo;
    else             nxt = cur + W'(1);
  end
endmodule

// File: rtl/cal_month_days.sv
module cal_month_days #(
  parameter int MW = 4,
  parameter int YW = 7,
  parameter int DW = 5
) (
  input  logic [MW-1:0] mon,
  input  logic [YW-1:0] year,
  input  logic [1:0]    cent_lo,
  output logic [DW-1:0] days
);
  // century*100 is always a multiple of 4; only the year field decides
  // divisibility by 4, and a zero year reduces the 400 rule to century mod 4
  logic leap;
  assign leap = (year != '0) ? (year[1:0] == 2'b00) : (cent_lo == 2'b00);

  always_comb begin
    case (mon)
      MW'(2):                          days = leap ? DW'(29) : DW'(28);
      MW'(4), MW'(6), MW'(9), MW'(11): days = DW'(30);
      default:                         days = DW'(31);
    endcase
  end
endmodule

// File: rtl/cal_counter.sv
module cal_counter
  import cal_rtc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  input  logic ld_tod,
  input  logic ld_cal,
  input  tod_t tod_in,
  input  cal_t cal_in,
  output tod_t tod_q,
  output cal_t cal_q
);
  logic [LANE_W-1:0] lane_cur [LANES];
  logic [LANE_W-1:0] lane_lo  [LANES];
  logic [LANE_W-1:0] lane_hi  [LANES];
  logic [LANE_W-1:0] lane_nxt [LANES];
  logic              carry    [LANES+1];
  logic [DAY_W-1:0]  month_len;
  logic              step;
  tod_t              tod_nxt;
  cal_t              cal_nxt;

  cal_month_days #(.MW(MON_W), .YW(YEAR_W), .DW(DAY_W)) u_mdays (
    .mon     (cal_q.mon),
    .year    (cal_q.year),
    .cent_lo (cal_q.cent[1:0]),
    .days    (month_len)
  );

  // lane order is the carry order: sec, min, hour, day, month, year, century
  always_comb begin
    lane_cur[0] = LANE_W'(tod_q.sec);
    lane_cur[1] = LANE_W'(tod_q.minute);
    lane_cur[2] = LANE_W'(tod_q.hour);
    lane_cur[3] = LANE_W'(tod_q.day);
    lane_cur[4] = LANE_W'(cal_q.mon);
    lane_cur[5] = LANE_W'(cal_q.year);
    lane_cur[6] = LANE_W'(cal_q.cent);
    lane_lo[0] = '0;  lane_hi[0] = LANE_W'(59);
    lane_lo[1] = '0;  lane_hi[1] = LANE_W'(59);
    lane_lo[2] = '0;  lane_hi[2] = LANE_W'(23);
    lane_lo[3] = LANE_W'(1); lane_hi[3] = LANE_W'(month_len);
    lane_lo[4] = LANE_W'(1); lane_hi[4] = LANE_W'(12);
    lane_lo[5] = '0;  lane_hi[5] = LANE_W'(99);
    lane_lo[6] = '0;  lane_hi[6] = LANE_W'((1 << CENT_W) - 1);
  end

  assign step     = run & tick & ~(ld_tod | ld_cal);
  assign carry[0] = step;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    cal_wrap_stage #(.W(LANE_W)) u_stage (
      .cur       (lane_cur[i]),
      .lo        (lane_lo[i]),
      .hi        (lane_hi[i]),
      .carry_in  (carry[i]),
      .nxt       (lane_nxt[i]),
      .carry_out (carry[i+1])
    );
  end

  always_comb begin
    tod_nxt.sec    = lane_nxt[0][SEC_W-1:0];
    tod_nxt.minute = lane_nxt[1][MIN_W-1:0];
    tod_nxt.hour   = lane_nxt[2][HOUR_W-1:0];
    tod_nxt.day    = lane_nxt[3][DAY_W-1:0];
    cal_nxt.mon    = lane_nxt[4][MON_W-1:0];
    cal_nxt.year   = lane_nxt[5][YEAR_W-1:0];
    cal_nxt.cent   = lane_nxt[6][CENT_W-1:0];
  end

  logic unused_lane_bits;
  assign unused_lane_bits = ^{lane_nxt[0][LANE_W-1:SEC_W], lane_nxt[1][LANE_W-1:MIN_W],
                              lane_nxt[2][LANE_W-1:HOUR_W], lane_nxt[3][LANE_W-1:DAY_W],
                              lane_nxt[4][LANE_W-1:MON_W], lane_nxt[6][LANE_W-1:CENT_W],
                              carry[LANES]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tod_q <= '0;
      cal_q <= '0;
    end else if (ld_tod || ld_cal) begin
      if (ld_tod) tod_q <= tod_in;
      if (ld_cal) cal_q <= cal_in;
    end else if (step) begin
      tod_q <= tod_nxt;
      cal_q <= cal_nxt;
    end
  end

  // R7: stopped clock with no load keeps both words
  a_r7_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld_tod && !ld_cal) |=> ($stable(tod_q) && $stable(cal_q)));

  // R8: second wraps to zero after 59
  a_r8_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !ld_tod && !ld_cal && tod_q.sec == SEC_W'(59)) |=> (tod_q.sec == '0));

  // R9: a legal month stays legal across a step
  a_r9_month_range: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !ld_tod && !ld_cal && cal_q.mon >= MON_W'(1) && cal_q.mon <= MON_W'(12))
    |=> (cal_q.mon >= MON_W'(1) && cal_q.mon <= MON_W'(12)));

  // R12: a time load leaves the date untouched even on a tick, and the reverse
  a_r12_tod_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_tod && !ld_cal) |=> $stable(cal_q));
  a_r12_cal_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_cal && !ld_tod) |=> $stable(tod_q));
endmodule

// File: rtl/cal_bus_regs.sv
module cal_bus_regs
  import cal_rtc_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_waddr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  tod_t              tod_cur,
  input  cal_t              cal_cur,
  output logic              run,
  output logic              unlock,
  output logic              ld_tod,
  output logic              ld_cal,
  output tod_t              tod_wr,
  output cal_t              cal_wr,
  output logic [BUS_W-1:0]  bus_rdata
);
  logic       hit;
  reg_sel_e   sel;
  logic       wr_acc;
  logic [1:0] ctrl_q;

  if (ADDR_W > SEL_W) begin : g_wide
    assign hit = (bus_waddr[ADDR_W-1:SEL_W] == '0);
  end else begin : g_exact
    assign hit = 1'b1;
  end

  assign sel    = reg_sel_e'(bus_waddr[SEL_W-1:0]);
  assign wr_acc = bus_sel & bus_wr & hit;

  always_ff @(posedge clk) begin
    if (!rst_n)                           ctrl_q <= '0;
    else if (wr_acc && sel == SEL_CTRL)   ctrl_q <= {bus_wdata[UNLOCK_BIT], bus_wdata[RUN_BIT]};
  end

  assign run    = ctrl_q[0];
  assign unlock = ctrl_q[1];
  assign ld_tod = wr_acc && (sel == SEL_TOD) && unlock;
  assign ld_cal = wr_acc && (sel == SEL_CAL) && unlock;
  assign tod_wr = unpack_tod(bus_wdata);
  assign cal_wr = unpack_cal(bus_wdata);

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr && hit) begin
      case (sel)
        SEL_TOD:  bus_rdata = pack_tod(tod_cur);
        SEL_CAL:  bus_rdata = pack_cal(cal_cur);
        SEL_CTRL: bus_rdata = BUS_W'({unlock, run});
        default:  bus_rdata = '0;
      endcase
    end
  end

  // R3: a control write always lands
  a_r3_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && hit && sel == SEL_CTRL)
    |=> ({unlock, run} == {$past(bus_wdata[UNLOCK_BIT]), $past(bus_wdata[RUN_BIT])}));
endmodule

// File: rtl/cal_rtc.sv
module cal_rtc
  import cal_rtc_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_waddr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  logic run, unlock, ld_tod, ld_cal;
  tod_t tod_wr, tod_cur;
  cal_t cal_wr, cal_cur;

  cal_bus_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_waddr (bus_waddr),
    .bus_wdata (bus_wdata),
    .tod_cur   (tod_cur),
    .cal_cur   (cal_cur),
    .run       (run),
    .unlock    (unlock),
    .ld_tod    (ld_tod),
    .ld_cal    (ld_cal),
    .tod_wr    (tod_wr),
    .cal_wr    (cal_wr),
    .bus_rdata (bus_rdata)
  );

  cal_counter u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .tick   (sec_tick),
    .ld_tod (ld_tod),
    .ld_cal (ld_cal),
    .tod_in (tod_wr),
    .cal_in (cal_wr),
    .tod_q  (tod_cur),
    .cal_q  (cal_cur)
  );

  // R6: a counter write while locked and without a step leaves both words
  a_r6_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_waddr <= ADDR_W'(1) && !unlock && !(run && sec_tick))
    |=> ($stable(tod_cur) && $stable(cal_cur)));
endmodule

// File: tb/cal_rtc_test.sv
`timescale 1ns/100ps
module cal_rtc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec_tick = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_waddr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  always #2.5 clk = ~clk;

  cal_rtc #(.ADDR_W(3)) uut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_waddr(bus_waddr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  // {time before, date before, time after one tick, date after one tick}
  localparam logic [127:0] VEC [12] = '{
    {32'h010A1405, 32'h00141803, 32'h010A1406, 32'h00141803},  // R7 plain step
    {32'h010A143B, 32'h00141803, 32'h010A1500, 32'h00141803},  // R8 second wrap
    {32'h05173B3B, 32'h00141803, 32'h06000000, 32'h00141803},  // R8 hour into day
    {32'h1E173B3B, 32'h00141804, 32'h01000000, 32'h00141805},  // R9 30-day month
    {32'h1F173B3B, 32'h00141801, 32'h01000000, 32'h00141802},  // R9 31-day month
    {32'h1F173B3B, 32'h0014180C, 32'h01000000, 32'h00141901},  // R9 December wrap
    {32'h1F173B3B, 32'h0013630C, 32'h01000000, 32'h00140001},  // R10 year 99 wrap
    {32'h1C173B3B, 32'h00141802, 32'h1D000000, 32'h00141802},  // R11 2024 leap
    {32'h1C173B3B, 32'h00141702, 32'h01000000, 32'h00141703},  // R11 2023 common
    {32'h1C173B3B, 32'h00140002, 32'h1D000000, 32'h00140002},  // R11 2000 leap
    {32'h1C173B3B, 32'h00130002, 32'h01000000, 32'h00130003},  // R11 1900 common
    {32'h1D173B3B, 32'h00141802, 32'h01000000, 32'h00141803}   // R11 Feb 29 end
  };

  function automatic string vec_tag(input int i);
    if (i == 0) return "R7";
    if (i < 3)  return "R8";
    if (i < 6)  return "R9";
    if (i == 6) return "R10";
    return "R11";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_waddr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_waddr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic tick_pulse();
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic write_on_tick(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_waddr = a; bus_wdata = d; sec_tick = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; sec_tick = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] rd2;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R2: every address reads zero after reset
    for (int a = 0; a < 8; a++) begin
      bus_read(3'(a), rd);
      check("R1 reset read", rd, 32'h0);
    end

    // R3: control keeps bits 1:0 only
    bus_write(3'd4, 32'hFFFF_FFFF);
    bus_read(3'd4, rd);
    check("R3 ctrl mask", rd, 32'h3);
    bus_write(3'd4, 32'h0);
    bus_read(3'd4, rd);
    check("R3 ctrl clear", rd, 32'h0);

    // R6: locked right after reset, write dropped
    bus_write(3'd0, 32'h01020304);
    bus_read(3'd0, rd);
    check("R6 locked tod", rd, 32'h0);

    // table walk: one tick across each boundary
    for (int i = 0; i < 12; i++) begin
      bus_write(3'd4, 32'h2);
      bus_write(3'd0, VEC[i][127:96]);
      bus_write(3'd1, VEC[i][95:64]);
      bus_write(3'd4, 32'h3);
      tick_pulse();
      bus_read(3'd0, rd);
      check({vec_tag(i), " time after tick"}, rd, VEC[i][63:32]);
      bus_read(3'd1, rd);
      check({vec_tag(i), " date after tick"}, rd, VEC[i][31:0]);
    end

    // R4 / R5: unused bits read zero
    bus_write(3'd4, 32'h2);
    bus_write(3'd0, 32'hFFFF_FFFF);
    bus_read(3'd0, rd);
    check("R4 tod mask", rd, 32'h1F1F3F3F);
    bus_write(3'd1, 32'hFFFF_FFFF);
    bus_read(3'd1, rd);
    check("R5 cal mask", rd, 32'h001F7F0F);

    // R2: alarm, status and gaps are inert
    bus_write(3'd2, 32'hFFFF_FFFF);
    bus_write(3'd5, 32'hFFFF_FFFF);
    bus_write(3'd3, 32'hFFFF_FFFF);
    bus_read(3'd2, rd);
    check("R2 alarm reads zero", rd, 32'h0);
    bus_read(3'd5, rd);
    check("R2 status reads zero", rd, 32'h0);
    bus_read(3'd3, rd);
    check("R2 gap reads zero", rd, 32'h0);
    bus_read(3'd0, rd);
    check("R2 tod untouched", rd, 32'h1F1F3F3F);
    bus_read(3'd4, rd);
    check("R2 ctrl untouched", rd, 32'h2);

    // R7: stopped clock ignores ticks
    bus_write(3'd0, 32'h010A1405);
    bus_write(3'd1, 32'h00141803);
    tick_pulse();
    tick_pulse();
    bus_read(3'd0, rd);
    check("R7 hold when stopped", rd, 32'h010A1405);

    // R7: running clock counts each tick
    bus_write(3'd4, 32'h3);
    tick_pulse();
    tick_pulse();
    tick_pulse();
    bus_read(3'd0, rd);
    check("R7 three ticks", rd, 32'h010A1408);

    // R12: write wins over a coincident tick
    write_on_tick(3'd0, 32'h02030405);
    bus_read(3'd0, rd);
    check("R12 tod write on tick", rd, 32'h02030405);
    bus_read(3'd1, rd2);
    check("R12 date frozen", rd2, 32'h00141803);
    tick_pulse();
    bus_read(3'd0, rd);
    check("R12 next tick counts", rd, 32'h02030406);
    write_on_tick(3'd1, 32'h00141804);
    bus_read(3'd0, rd);
    check("R12 tod frozen", rd, 32'h02030406);
    bus_read(3'd1, rd);
    check("R12 date write on tick", rd, 32'h00141804);

    // R6: running but locked, writes dropped
    bus_write(3'd4, 32'h1);
    bus_write(3'd0, 32'h05050505);
    bus_read(3'd0, rd);
    check("R6 locked tod running", rd, 32'h02030406);
    bus_write(3'd1, 32'h00100101);
    bus_read(3'd1, rd);
    check("R6 locked date running", rd, 32'h00141804);

    // R1: reset during operation
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    bus_read(3'd4, rd);
    check("R1 ctrl after reset", rd, 32'h0);
    bus_read(3'd0, rd);
    check("R1 tod after reset", rd, 32'h0);
    bus_read(3'd1, rd);
    check("R1 date after reset", rd, 32'h0);

    finish_run();
  end
endmodule